// File: doc/BRIEF.md
# Input Capture Edge Selector

This block timestamps transitions on four capture pins. A single control register holds an edge-selection field for each channel. Each pin passes through a synchroniser. When the synchronised level moves in the direction that the channel's field selects, the value on a free-running counter input is stored in that channel's capture register. The same transition raises a sticky capture flag.

The fourth channel shares its pin with an output-compare function. It records events only while a mode select input puts the pin in capture mode. The counter, interrupt generation and any software-visible flag handling beyond a clear input belong to the surrounding logic.

Top module: `edge_capture_unit`

## Requirements
- R1: The control register resets to 0x00. A write loads it at any time, and its value appears on the read port from the next clock onward. Without a write it holds its value.
- R2: The control register places the channel fields from bit 7 down in this order: channel 4 in bits [7:6], channel 1 in [5:4], channel 2 in [3:2], channel 3 in [1:0]. Pins map as pin_i[0] to channel 1 up to pin_i[3] to channel 4, and the capture value of channel n sits in cap_val_o[16n-1:16n-16].
- R3: Field value 01 captures on a low-to-high transition of the pin only. A falling transition leaves the channel unchanged.
- R4: Field value 10 captures on a high-to-low transition only. A rising transition leaves the channel unchanged.
- R5: Field value 11 captures on both rising and falling transitions.
- R6: Field value 00 disables the channel. Transitions change neither its capture value nor its flag.
- R7: A pin level first sampled at clock edge k produces a capture at edge k+2. The stored value is the counter input present just before edge k+2, and the flag and value become visible after that edge.
- R8: A capture sets the channel's flag. The flag stays set until a clear pulse on that channel's flag_clr_i bit. A capture and a clear in the same cycle leave the flag set.
- R9: A later capture overwrites the stored counter value.
- R10: Channel 4 captures only while ch4_capture_mode_i is 1. While it is 0, channel 4's value and flag are untouched by its pin.
- R11: Reset (rst_ni low) clears all capture values and flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| pin_i | input | 4 | Asynchronous capture pins, bit 0 is channel 1 |
| count_i | input | 16 | Counter value to be captured |
| ch4_capture_mode_i | input | 1 | 1 selects capture mode for the shared channel 4 pin |
| flag_clr_i | input | 4 | Per-channel flag clear pulse |
| cap_val_o | output | 64 | Four packed 16-bit capture values |
| cap_flag_o | output | 4 | Per-channel capture flags |

## Verification
The bench builds the block with its default parameters: four channels, a 16-bit counter, two synchroniser stages and channel 4 as the shared one. With these values, the out-of-order field layout and the gating of the shared channel are both reachable. The exact two-edge capture latency can be observed with a counter value that changes every cycle. A table walk covers every edge encoding on every channel and single-field register values that pin down each field's position. Directed cases then cover latency, a clear that collides with a capture, and reset in mid-run.

// File: rtl/icap_pkg.sv
package icap_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  // Field slot of a channel in the control register, counted from bit 0.
  // The shared (last) channel takes the top slot; the others run downward.
  function automatic int unsigned field_slot(input int unsigned ch,
                                             input int unsigned n_ch);
    if (ch == n_ch - 1) begin
      return n_ch - 1;
    end
    return n_ch - 2 - ch;
  endfunction

endpackage

// File: rtl/icap_rst_sync.sv
module icap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/icap_ctrl_reg.sv
module icap_ctrl_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] ctrl_q;
  logic [WIDTH-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (we_i) begin
      ctrl_d = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  assign q_o = ctrl_q;

  AST_CTRL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o == $past(wdata_i))); // R1
  AST_CTRL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o)); // R1

endmodule

// File: rtl/icap_edge_det.sv
module icap_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;
  logic              level;

  assign level = sync_q[STAGES-1];

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin_i};
    prev_d = level;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = level & ~prev_q;
  assign fall_o = ~level & prev_q;

  AST_EDGE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R7

endmodule

// File: rtl/icap_channel.sv
module icap_channel
  import icap_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  edge_sel_e        sel_i,
  input  logic             en_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o
);

  logic             fire;
  logic [CNT_W-1:0] cap_q;
  logic [CNT_W-1:0] cap_d;
  logic             flag_q;
  logic             flag_d;

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: fire = rise_i;
      EDGE_FALL: fire = fall_i;
      EDGE_BOTH: fire = rise_i | fall_i;
      default:   fire = 1'b0;
    endcase
    fire = fire & en_i;
  end

  always_comb begin
    cap_d  = cap_q;
    flag_d = flag_q;
    if (clr_i) begin
      flag_d = 1'b0;
    end
    if (fire) begin
      cap_d  = count_i;
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cap_q  <= cap_d;
      flag_q <= flag_d;
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;

  AST_RISE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sel_i == EDGE_RISE && rise_i) |=> (cap_o == $past(count_i))); // R3
  AST_FALL_IGNORES_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == EDGE_FALL && rise_i && !clr_i) |=> ($stable(cap_o) && $stable(flag_o))); // R4
  AST_BOTH_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sel_i == EDGE_BOTH && (rise_i || fall_i)) |=> flag_o); // R5
  AST_OFF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == EDGE_OFF && !clr_i) |=> ($stable(cap_o) && $stable(flag_o))); // R6
  AST_FLAG_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !rise_i && !fall_i) |=> !flag_o); // R8

endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import icap_pkg::*;
#(
  parameter int unsigned CHANNELS    = 4,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      reg_we_i,
  input  logic [2*CHANNELS-1:0]     reg_wdata_i,
  output logic [2*CHANNELS-1:0]     reg_rdata_o,
  input  logic [CHANNELS-1:0]       pin_i,
  input  logic [CNT_W-1:0]          count_i,
  input  logic                      ch4_capture_mode_i,
  input  logic [CHANNELS-1:0]       flag_clr_i,
  output logic [CHANNELS*CNT_W-1:0] cap_val_o,
  output logic [CHANNELS-1:0]       cap_flag_o
);

  localparam int unsigned CTRL_W    = 2 * CHANNELS;
  localparam int unsigned SHARED_CH = CHANNELS - 1;

  logic              rst_n_int;
  logic [CTRL_W-1:0] ctrl;

  icap_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_int)
  );

  icap_ctrl_reg #(.WIDTH(CTRL_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .q_o     (ctrl)
  );

  assign reg_rdata_o = ctrl;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
    localparam int unsigned SLOT = field_slot(ch, CHANNELS);
    logic      rise;
    logic      fall;
    logic      enable;
    edge_sel_e sel;

    assign sel = edge_sel_e'(ctrl[2*SLOT +: 2]);

    if (ch == SHARED_CH) begin : g_shared
      assign enable = ch4_capture_mode_i;
    end else begin : g_plain
      assign enable = 1'b1;
    end

    icap_edge_det #(.STAGES(SYNC_STAGES)) u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_n_int),
      .pin_i  (pin_i[ch]),
      .rise_o (rise),
      .fall_o (fall)
    );

    icap_channel #(.CNT_W(CNT_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_n_int),
      .sel_i   (sel),
      .en_i    (enable),
      .rise_i  (rise),
      .fall_i  (fall),
      .count_i (count_i),
      .clr_i   (flag_clr_i[ch]),
      .cap_o   (cap_val_o[ch*CNT_W +: CNT_W]),
      .flag_o  (cap_flag_o[ch])
    );
  end

  AST_SHARED_GATED: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !ch4_capture_mode_i |=> $stable(cap_val_o[SHARED_CH*CNT_W +: CNT_W])); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_n_int |-> (cap_flag_o == '0 && cap_val_o == '0)); // R11

endmodule

// File: tb/sim_edge_capture_unit.sv
`timescale 1ns/1ps
module sim_edge_capture_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  pins = '0;
  logic [15:0] count = '0;
  logic        mode = 1'b1;
  logic [3:0]  clr = '0;
  logic [63:0] caps;
  logic [3:0]  flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  edge_capture_unit u0 (
    .clk_i              (clk),
    .rst_ni             (rst_n),
    .reg_we_i           (we),
    .reg_wdata_i        (wdata),
    .reg_rdata_o        (rdata),
    .pin_i              (pins),
    .count_i            (count),
    .ch4_capture_mode_i (mode),
    .flag_clr_i         (clr),
    .cap_val_o          (caps),
    .cap_flag_o         (flags)
  );

  // {ctrl, mode, pins, count, clr, expected flags, channels that capture}
  localparam int NV = 17;
  localparam logic [40:0] VEC [NV] = '{
    {8'h55, 1'b1, 4'b0001, 16'h1111, 4'b0000, 4'b0001, 4'b0001}, // R3 ch1 rise
    {8'h55, 1'b1, 4'b0011, 16'h2222, 4'b0000, 4'b0011, 4'b0010}, // R3 ch2 rise
    {8'h55, 1'b1, 4'b0001, 16'h3333, 4'b0000, 4'b0011, 4'b0000}, // R3 fall ignored
    {8'hAA, 1'b1, 4'b0000, 16'h4444, 4'b0011, 4'b0001, 4'b0001}, // R4 ch1 fall
    {8'hAA, 1'b1, 4'b0100, 16'h5555, 4'b0000, 4'b0001, 4'b0000}, // R4 rise ignored
    {8'hAA, 1'b1, 4'b0000, 16'h6666, 4'b0000, 4'b0101, 4'b0100}, // R4 ch3 fall
    {8'hFF, 1'b1, 4'b1111, 16'h7777, 4'b0000, 4'b1111, 4'b1111}, // R5 all rise
    {8'hFF, 1'b1, 4'b0000, 16'h8888, 4'b1111, 4'b1111, 4'b1111}, // R5 R9 all fall
    {8'h00, 1'b1, 4'b1111, 16'h9999, 4'b1111, 4'b0000, 4'b0000}, // R6 off
    {8'h00, 1'b1, 4'b0000, 16'hAAAA, 4'b0000, 4'b0000, 4'b0000}, // R6 off
    {8'h40, 1'b1, 4'b1111, 16'hBBBB, 4'b0000, 4'b1000, 4'b1000}, // R2 ch4 slot
    {8'h20, 1'b1, 4'b0000, 16'hCCCC, 4'b1000, 4'b0001, 4'b0001}, // R2 ch1 slot
    {8'h04, 1'b1, 4'b1111, 16'hDDDD, 4'b0001, 4'b0010, 4'b0010}, // R2 ch2 slot
    {8'h02, 1'b1, 4'b0000, 16'hEEEE, 4'b0010, 4'b0100, 4'b0100}, // R2 ch3 slot
    {8'hFF, 1'b0, 4'b1000, 16'h1234, 4'b0100, 4'b0000, 4'b0000}, // R10 gated
    {8'hFF, 1'b0, 4'b0000, 16'h4321, 4'b0000, 4'b0000, 4'b0000}, // R10 gated
    {8'hFF, 1'b1, 4'b1000, 16'h5678, 4'b0000, 4'b1000, 4'b1000}  // R10 enabled
  };

  logic [15:0] exp_cap [4];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_caps(input string req);
    for (int c = 0; c < 4; c++) begin
      check(req, {48'd0, caps[c*16 +: 16]}, {48'd0, exp_cap[c]});
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [40:0] v;
    for (int c = 0; c < 4; c++) exp_cap[c] = '0;
    repeat (3) @(negedge clk);
    // R11 R1: state while in reset
    check("R1 reset ctrl", {56'd0, rdata}, 64'd0);
    check("R11 reset flags", {60'd0, flags}, 64'd0);
    check("R11 reset caps", caps, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ctrl after release", {56'd0, rdata}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      @(negedge clk);
      we = 1'b1; wdata = v[40:33]; mode = v[32]; count = v[27:12]; clr = v[11:8];
      @(negedge clk);
      we = 1'b0; clr = '0; pins = v[31:28];
      check("R1 readback", {56'd0, rdata}, {56'd0, v[40:33]});
      repeat (3) @(negedge clk);
      for (int c = 0; c < 4; c++) if (v[c]) exp_cap[c] = v[27:12];
      check("R2 R3 R4 R5 R6 R8 R10 flags", {60'd0, flags}, {60'd0, v[7:4]});
      check_caps("R2 R3 R4 R5 R6 R9 R10 values");
    end

    // R7: latency with a counter that changes every cycle; pins now 1000
    @(negedge clk); clr = 4'hF;
    @(negedge clk); clr = '0; pins[0] = 1'b1; count = 16'hA001;
    @(negedge clk); count = 16'hA002;
    check("R7 no flag after one edge", {63'd0, flags[0]}, 64'd0);
    @(negedge clk); count = 16'hA003;
    check("R7 no flag after two edges", {63'd0, flags[0]}, 64'd0);
    @(negedge clk); count = 16'hA004;
    check("R7 flag after third edge", {63'd0, flags[0]}, 64'd1);
    check("R7 captured value", {48'd0, caps[15:0]}, 64'h0000_0000_0000_A003);

    // R8: clear coinciding with capture leaves flag set
    @(negedge clk); pins[1] = 1'b1;
    @(negedge clk);
    @(negedge clk); clr = 4'b0010;
    @(negedge clk); clr = '0;
    check("R8 capture beats clear", {63'd0, flags[1]}, 64'd1);
    repeat (5) @(negedge clk);
    check("R8 flag held", {63'd0, flags[1]}, 64'd1);
    clr = 4'b0010;
    @(negedge clk); clr = '0;
    check("R8 flag cleared", {63'd0, flags[1]}, 64'd0);
    check("R8 other flag kept", {63'd0, flags[0]}, 64'd1);

    // R11: reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 caps cleared", caps, 64'd0);
    check("R11 flags cleared", {60'd0, flags}, 64'd0);
    check("R1 ctrl cleared", {56'd0, rdata}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule